// File: doc/BRIEF.md
# Command Buffer Write/Output Sequencer

This block holds a sixteen-entry command of 4-bit characters that a host processor loads one nibble at a time. The host puts a RAM address on its address port, drives the nibble on the data bus, and pulses an active-low output strobe while its decoded port select is also low. It repeats this for all sixteen locations. During the same window the host may also load a preset count for the format counter.

A write timer advances on a synchronous enable pulse and closes the write window after a fixed number of pulses. The write-busy output then drops, which tells the host that writing has ended, and the format counter is armed with the preset. After a further fixed gap the output cycle begins. RAM addressing passes from the host port to the format counter. Each enable pulse of the slow bit clock then presents the addressed nibble and steps the counter down. When the entry at address zero has been presented, the block goes idle. A start command or a synchronous reset opens a new write window at any time.

Top module: `cmdseq_top`

## Requirements
- R1: After reset, write_busy_o is 1, out_active_o is 0 and data_o is 0; write_busy_o and out_active_o are never both 1.
- R2: A RAM write happens on a clock edge only when host_sel_n_i and host_strobe_n_i are both 0 during the write window. It stores host_data_i at host_addr_i. A strobe with the select high, or a select with the strobe high, stores nothing.
- R3: write_busy_o falls on the edge that takes the 768th tick_i pulse counted since reset or start.
- R4: Once write_busy_o is 0, host strobes do not change the RAM and preset loads do not change the output length.
- R5: out_active_o rises on the edge that takes the 1024th tick_i pulse, which is 256 pulses after the write window closed.
- R6: bit_tick_i has no effect on data_o while out_active_o is 0.
- R7: During output, each bit_tick_i pulse loads data_o with the RAM entry at the format count. The count starts at the preset and steps down by one per pulse, so addresses are read in the order P, P-1, ..., 0. Without a pulse, data_o holds its value.
- R8: The pulse that presents address 0 clears out_active_o. The block then stays idle with write_busy_o at 0 until the next start.
- R9: start_i, in any phase including mid-output, sets write_busy_o, clears out_active_o and restarts the timer from zero.
- R10: preset_load_i during the write window stores preset_i, and the last such load before the window ends sets the preset. The preset is kept across start commands.
- R11: tick_i pulses need not be consecutive; only cycles with tick_i high advance the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Host start command: opens a new write window |
| tick_i | input | 1 | Write-timer enable pulse |
| bit_tick_i | input | 1 | Slow bit-clock enable pulse for the format counter |
| host_sel_n_i | input | 1 | Decoded buffer port select, active low |
| host_strobe_n_i | input | 1 | Host output strobe, active low |
| host_addr_i | input | 4 | RAM address from the host address port |
| host_data_i | input | 4 | Nibble on the host data bus |
| preset_load_i | input | 1 | Format command: load preset_i as the count preset |
| preset_i | input | 4 | Format counter preset value |
| write_busy_o | output | 1 | High while the write window is open |
| out_active_o | output | 1 | High during the output cycle |
| data_o | output | 4 | Nibble presented during the output cycle |

## Verification
The hardest cases to reach are the gap between the end of the write window and the start of output, and a start that arrives in the middle of output. Both lie behind a thousand timer pulses. The stimulus counts tick_i pulses exactly up to one short of each boundary, checks the outputs there, and then applies the deciding pulse. Inside the gap it tries host writes, a new preset and bit-clock pulses; the later playout then shows that none of them took effect. A second pass spaces the timer pulses with idle cycles. A third pass stops playout after two characters with a start command and counts the new window from zero.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int ADDR_W_DEF      = 4;
    localparam int DATA_W_DEF      = 4;
    localparam int WRITE_TICKS_DEF = 768;
    localparam int GAP_TICKS_DEF   = 256;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_WRITE  = 2'd1,
        PH_GAP    = 2'd2,
        PH_OUTPUT = 2'd3
    } phase_e;

    function automatic logic host_write_fire(input logic sel_n,
                                             input logic strobe_n,
                                             input phase_e ph);
        return (ph == PH_WRITE) && !sel_n && !strobe_n;
    endfunction

    function automatic logic owner_is_counter(input phase_e ph);
        return ph == PH_OUTPUT;
    endfunction

endpackage

// File: rtl/cmdseq_phase_timer.sv
module cmdseq_phase_timer
    import cmdseq_pkg::*;
#(
    parameter int WRITE_TICKS = WRITE_TICKS_DEF,
    parameter int GAP_TICKS   = GAP_TICKS_DEF,
    localparam int TMR_W      = $clog2(WRITE_TICKS + GAP_TICKS + 1)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  logic   tick_i,
    input  logic   play_done_i,
    output phase_e phase_o,
    output logic   arm_o
);
    localparam logic [TMR_W-1:0] LAST_WRITE = TMR_W'(WRITE_TICKS - 1);
    localparam logic [TMR_W-1:0] LAST_GAP   = TMR_W'(WRITE_TICKS + GAP_TICKS - 1);

    phase_e           phase_q;
    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            phase_q <= PH_WRITE;
            tmr_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_WRITE: if (tick_i) begin
                    tmr_q <= tmr_q + 1'b1;
                    if (tmr_q == LAST_WRITE) phase_q <= PH_GAP;
                end
                PH_GAP: if (tick_i) begin
                    tmr_q <= tmr_q + 1'b1;
                    if (tmr_q == LAST_GAP) phase_q <= PH_OUTPUT;
                end
                PH_OUTPUT: if (play_done_i) phase_q <= PH_IDLE;
                default: ;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign arm_o   = (phase_q == PH_WRITE) && tick_i && (tmr_q == LAST_WRITE);

endmodule

// File: rtl/cmdseq_nibble_ram.sv
module cmdseq_nibble_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/cmdseq_fmt_counter.sv
module cmdseq_fmt_counter
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_i,
    input  logic              arm_i,
    input  logic              preset_load_i,
    input  logic [ADDR_W-1:0] preset_i,
    input  logic              bit_tick_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] ram_rdata_i,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o
);
    logic [ADDR_W-1:0] preset_q;
    logic [ADDR_W-1:0] fcnt_q;
    logic [ADDR_W-1:0] preset_now;
    logic              load_ok;
    logic              step;

    assign load_ok    = (phase_i == PH_WRITE) && preset_load_i;
    assign preset_now = load_ok ? preset_i : preset_q;
    assign step       = owner_is_counter(phase_i) && bit_tick_i;
    assign done_o     = step && (fcnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            preset_q <= '0;
            fcnt_q   <= '0;
            data_o   <= '0;
        end else begin
            if (load_ok) preset_q <= preset_i;
            if (arm_i) begin
                fcnt_q <= preset_now;
            end else if (step) begin
                data_o <= ram_rdata_i;
                if (fcnt_q != '0) fcnt_q <= fcnt_q - 1'b1;
            end
        end
    end

    assign ram_addr_o = owner_is_counter(phase_i) ? fcnt_q : host_addr_i;

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int DATA_W      = DATA_W_DEF,
    parameter int WRITE_TICKS = WRITE_TICKS_DEF,
    parameter int GAP_TICKS   = GAP_TICKS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic              bit_tick_i,
    input  logic              host_sel_n_i,
    input  logic              host_strobe_n_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_data_i,
    input  logic              preset_load_i,
    input  logic [ADDR_W-1:0] preset_i,
    output logic              write_busy_o,
    output logic              out_active_o,
    output logic [DATA_W-1:0] data_o
);
    phase_e            phase;
    logic              arm;
    logic              play_done;
    logic              host_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_rdata;

    assign host_we = host_write_fire(host_sel_n_i, host_strobe_n_i, phase);

    cmdseq_phase_timer #(
        .WRITE_TICKS(WRITE_TICKS),
        .GAP_TICKS  (GAP_TICKS)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .tick_i     (tick_i),
        .play_done_i(play_done),
        .phase_o    (phase),
        .arm_o      (arm)
    );

    cmdseq_nibble_ram #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_ram (
        .clk    (clk),
        .we_i   (host_we),
        .waddr_i(ram_addr),
        .wdata_i(host_data_i),
        .raddr_i(ram_addr),
        .rdata_o(ram_rdata)
    );

    cmdseq_fmt_counter #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fmt (
        .clk          (clk),
        .rst          (rst),
        .phase_i      (phase),
        .arm_i        (arm),
        .preset_load_i(preset_load_i),
        .preset_i     (preset_i),
        .bit_tick_i   (bit_tick_i),
        .host_addr_i  (host_addr_i),
        .ram_rdata_i  (ram_rdata),
        .ram_addr_o   (ram_addr),
        .data_o       (data_o),
        .done_o       (play_done)
    );

    assign write_busy_o = (phase == PH_WRITE);
    assign out_active_o = (phase == PH_OUTPUT);

endmodule

// File: rtl/cmdseq_checker.sv
module cmdseq_checker #(
    parameter int DATA_W      = 4,
    parameter int WRITE_TICKS = 768,
    parameter int GAP_TICKS   = 256,
    localparam int CNT_W      = $clog2(WRITE_TICKS + GAP_TICKS + 1) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              tick_i,
    input logic              bit_tick_i,
    input logic              host_we,
    input logic              write_busy_o,
    input logic              out_active_o,
    input logic [DATA_W-1:0] data_o
);
    logic [CNT_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst || start_i) seen_q <= '0;
        else if (tick_i && !out_active_o && seen_q != '1) seen_q <= seen_q + 1'b1;
    end

    assert_phase_excl_R1: assert property (@(posedge clk) disable iff (rst)
        !(write_busy_o && out_active_o));

    assert_write_needs_window_R2: assert property (@(posedge clk) disable iff (rst)
        host_we |-> write_busy_o);

    assert_window_length_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(write_busy_o) |-> seen_q == CNT_W'(WRITE_TICKS));

    assert_gap_length_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(out_active_o) |-> seen_q == CNT_W'(WRITE_TICKS + GAP_TICKS));

    assert_idle_data_R6: assert property (@(posedge clk) disable iff (rst)
        !out_active_o |=> $stable(data_o));

    assert_hold_data_R7: assert property (@(posedge clk) disable iff (rst)
        (out_active_o && !bit_tick_i) |=> $stable(data_o));

    assert_end_idle_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(out_active_o) |-> (write_busy_o == $past(start_i)));

    assert_start_opens_R9: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (write_busy_o && !out_active_o));

endmodule

bind cmdseq_top cmdseq_checker #(
    .DATA_W     (DATA_W),
    .WRITE_TICKS(WRITE_TICKS),
    .GAP_TICKS  (GAP_TICKS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .tick_i      (tick_i),
    .bit_tick_i  (bit_tick_i),
    .host_we     (host_we),
    .write_busy_o(write_busy_o),
    .out_active_o(out_active_o),
    .data_o      (data_o)
);

// File: tb/tb_cmdseq_top.sv
`timescale 1ns/1ps
module tb_cmdseq_top;
    import cmdseq_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0, tick_i = 1'b0, bit_tick_i = 1'b0;
    logic       host_sel_n_i = 1'b1, host_strobe_n_i = 1'b1;
    logic [3:0] host_addr_i = '0, host_data_i = '0;
    logic       preset_load_i = 1'b0;
    logic [3:0] preset_i = '0;
    logic       write_busy_o, out_active_o;
    logic [3:0] data_o;

    int checks = 0, errors = 0;
    logic [3:0] model [16];
    logic [3:0] exp_q [$];
    string      tag_q [$];
    event       sample_ev;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    cmdseq_top dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [3:0] a, input logic [3:0] d,
                              input logic sel_n, input logic stb_n);
        @(negedge clk);
        host_addr_i = a; host_data_i = d; host_sel_n_i = sel_n; host_strobe_n_i = stb_n;
        @(negedge clk);
        host_sel_n_i = 1'b1; host_strobe_n_i = 1'b1;
    endtask

    task automatic load_preset(input logic [3:0] p);
        @(negedge clk); preset_i = p; preset_load_i = 1'b1;
        @(negedge clk); preset_load_i = 1'b0;
    endtask

    task automatic ticks(input int n, input int spacing);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
            repeat (spacing) @(negedge clk);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    // driver: pushes the expected nibble, then pulses the bit clock
    task automatic play(input logic [3:0] addr, input string req);
        exp_q.push_back(model[addr]);
        tag_q.push_back(req);
        @(negedge clk); bit_tick_i = 1'b1;
        @(negedge clk); bit_tick_i = 1'b0;
        ->sample_ev;
        @(negedge clk);
    endtask

    task automatic stray_bit(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick_i = 1'b1;
            @(negedge clk); bit_tick_i = 1'b0;
        end
    endtask

    // monitor: pops the next expected nibble and compares
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 empty queue", data_o, 0);
            end else begin
                automatic logic [3:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(data_o === e, t, data_o, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(write_busy_o == 1'b1, "R1 busy after reset", write_busy_o, 1);
        chk(out_active_o == 1'b0, "R1 output idle after reset", out_active_o, 0);
        chk(data_o == 4'd0, "R1 data after reset", data_o, 0);

        // pass 1: full write, preset loaded twice, last one wins (R10)
        for (int i = 0; i < 16; i++) begin
            model[i] = 4'((i * 7 + 3) & 15);
            host_write(4'(i), model[i], 1'b0, 1'b0);
        end
        host_write(4'd5, ~model[5], 1'b1, 1'b0);   // R2: select high
        host_write(4'd5, ~model[5], 1'b0, 1'b1);   // R2: strobe high
        load_preset(4'd12);
        load_preset(4'd15);

        ticks(767, 0);
        chk(write_busy_o == 1'b1, "R3 busy before 768th tick", write_busy_o, 1);
        ticks(1, 0);
        chk(write_busy_o == 1'b0, "R3 window closed at 768", write_busy_o, 0);

        // inside the gap: writes, preset and bit ticks must do nothing (R4, R6)
        host_write(4'd3, ~model[3], 1'b0, 1'b0);
        load_preset(4'd2);
        stray_bit(2);
        chk(data_o == 4'd0, "R6 bit tick in gap", data_o, 0);
        chk(out_active_o == 1'b0, "R6 no output in gap", out_active_o, 0);

        ticks(255, 0);
        chk(out_active_o == 1'b0, "R5 output not yet at 1023", out_active_o, 0);
        ticks(1, 0);
        chk(out_active_o == 1'b1, "R5 output starts at 1024", out_active_o, 1);

        for (int a = 15; a >= 1; a--) play(4'(a), "R7 R2 R4 playout order");
        chk(out_active_o == 1'b1, "R4 preset change ignored", out_active_o, 1);
        play(4'd0, "R7 last character");
        chk(out_active_o == 1'b0, "R8 output ends after address 0", out_active_o, 0);
        chk(write_busy_o == 1'b0, "R8 idle, no window", write_busy_o, 0);
        stray_bit(2);
        ticks(3, 0);
        chk(data_o == model[0], "R8 idle holds data", data_o, model[0]);
        chk(out_active_o == 1'b0, "R8 stays idle", out_active_o, 0);

        // pass 2: start, preset 3, spaced timer pulses (R9, R10, R11)
        do_start();
        chk(write_busy_o == 1'b1, "R9 start reopens window", write_busy_o, 1);
        load_preset(4'd3);
        ticks(767, 2);
        chk(write_busy_o == 1'b1, "R11 spaced ticks, 767", write_busy_o, 1);
        ticks(1, 2);
        chk(write_busy_o == 1'b0, "R11 spaced ticks, 768", write_busy_o, 0);
        ticks(256, 2);
        chk(out_active_o == 1'b1, "R11 spaced ticks, output", out_active_o, 1);
        for (int a = 3; a >= 0; a--) play(4'(a), "R10 short playout");
        chk(out_active_o == 1'b0, "R10 length follows preset 3", out_active_o, 0);

        // pass 3: start during output restarts the timer (R9)
        do_start();
        ticks(1024, 0);
        chk(out_active_o == 1'b1, "R10 preset kept over start", out_active_o, 1);
        play(4'd3, "R9 playout before restart");
        play(4'd2, "R9 playout before restart");
        do_start();
        chk(write_busy_o == 1'b1 && out_active_o == 1'b0, "R9 start mid-output",
            {30'd0, write_busy_o, out_active_o}, 2);
        ticks(767, 0);
        chk(write_busy_o == 1'b1, "R9 timer restarted, 767", write_busy_o, 1);
        ticks(1, 0);
        chk(write_busy_o == 1'b0, "R9 timer restarted, 768", write_busy_o, 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule